// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a CPU bus and a cartridge image. It watches CPU stores into the ROM window (0x0000-0x7FFF) and treats them as writes to the bank-control registers. From those registers it drives the switchable ROM bank, the external RAM bank and an enable for external RAM. It also builds the physical ROM and RAM addresses and gates the external RAM data path.

The header cartridge-type byte sets the controller's behaviour. The block captures it once, after reset. Four behaviours are built:
- none: no control registers.
- narrow: a 5-bit bank field, where a written zero becomes one.
- wide-with-RAM-select: a 7-bit bank field, zero becomes one, plus a RAM bank register.
- wide-raw: a 7-bit bank field where zero is kept.

Codes that belong to controller kinds not built here give a mode in which every control write is ignored. A ROM size input, given as a count of 16 KiB banks, limits which banks can be selected.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While reset is held and after it is released, the ROM bank is 1, the RAM bank is 0 and the RAM enable is 0.
- R2: The type byte is decoded as follows:
  - 0x00, 0x08 and 0x09 give none.
  - 0x01 to 0x03 give narrow.
  - 0x0F to 0x13 give wide-with-RAM-select.
  - 0x05, 0x06, 0x15 to 0x17 and 0x22 give ignore-all.
  - Every other code gives wide-raw.
- R3: In narrow, wide-with-RAM-select and wide-raw, a write with address[15:13]=0 sets the RAM enable when the data is 0x0A and clears it when the data is 0x00. Any other data leaves the enable unchanged.
- R4: In narrow mode, a write with address[15:13]=1 gives a candidate bank. Its bits [4:0] are data[4:0], with 0 replaced by 1. Its upper bits are kept from the current bank.
- R5: In wide-with-RAM-select mode, a write with address[15:13]=1 gives the candidate bank data[6:0], with 0 replaced by 1.
- R6: In wide-raw mode, a write with address[15:13]=1 gives the candidate bank data[6:0]; 0 is kept as 0.
- R7: In wide-with-RAM-select mode only, a write with address[15:13]=2 and data below 4 loads data[1:0] into the RAM bank. Larger data is ignored, and this register cannot change in any other mode.
- R8: A candidate ROM bank is applied only when (bank+1)×16 KiB does not exceed the ROM size, that is, when bank < rom_banks_i. Otherwise the old bank stays.
- R9: In none and ignore-all modes, no write changes the ROM bank, the RAM bank or the RAM enable.
- R10: rom_addr_o is {0, addr[13:0]} for 0x0000-0x3FFF and {rom_bank, addr[13:0]} for 0x4000-0x7FFF.
- R11: ram_addr_o is {ram_bank, addr[12:0]}. While RAM is disabled, bus_ram_rdata_o reads 0xFF and ram_we_o stays low. While RAM is enabled, bus_ram_rdata_o passes ram_rdata_i, and ram_we_o follows a bus write into 0xA000-0xBFFF.
- R12: The type is captured on the first clock edge after reset is released. A control write presented in that same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cart_type_i | input | 8 | Header cartridge-type byte, held stable |
| rom_banks_i | input | 8 | ROM size as a count of 16 KiB banks |
| bus_addr_i | input | 16 | CPU address |
| bus_wdata_i | input | 8 | CPU write data |
| bus_we_i | input | 1 | CPU write strobe |
| ram_rdata_i | input | 8 | Read data from external RAM |
| rom_addr_o | output | 21 | Physical ROM byte address |
| rom_bank_o | output | 7 | Current switchable ROM bank |
| ram_bank_o | output | 2 | Current external RAM bank |
| ram_en_o | output | 1 | External RAM enable |
| ram_addr_o | output | 15 | Physical external RAM address |
| ram_we_o | output | 1 | Gated external RAM write strobe |
| bus_ram_rdata_o | output | 8 | Gated external RAM read data to the CPU |

## Verification
The hardest case to reach is the capture cycle, where a control write arrives in the same cycle that the type byte is taken in. The bench releases reset with a write to the enable register already on the bus, to show that this write is lost.

Bank rejection is the other hard case, because it needs a small ROM size together with a write that selects a bank above it. Each cartridge type is run with a different bank count, some as small as 2 or 4. Directed writes of the last legal bank, the first illegal bank and zero are followed by weighted random traffic that favours 0x0A, 0x00 and small values.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  typedef enum logic [2:0] {
    MODE_NONE,
    MODE_NARROW,
    MODE_WSEL,
    MODE_WRAW,
    MODE_OFF
  } cart_mode_e;

  function automatic cart_mode_e decode_type(input logic [7:0] t);
    cart_mode_e m;
    if (t == 8'h00 || t == 8'h08 || t == 8'h09)      m = MODE_NONE;
    else if (t >= 8'h01 && t <= 8'h03)               m = MODE_NARROW;
    else if (t >= 8'h0F && t <= 8'h13)               m = MODE_WSEL;
    else if (t == 8'h05 || t == 8'h06 || t == 8'h22 ||
             (t >= 8'h15 && t <= 8'h17))             m = MODE_OFF;
    else                                             m = MODE_WRAW;
    return m;
  endfunction
endpackage

// File: rtl/cart_mode_latch.sv
module cart_mode_latch
  import cart_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cart_type_i,
  output cart_mode_e mode_o,
  output logic       cfg_done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= MODE_NONE;
      cfg_done_o <= 1'b0;
    end else if (!cfg_done_o) begin
      mode_o     <= decode_type(cart_type_i);
      cfg_done_o <= 1'b1;
    end
  end

  // R12
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> $stable(mode_o) && cfg_done_o);
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter int NARROW_W   = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  cart_mode_e            mode_i,
  input  logic                  we_i,
  input  logic [2:0]            sel_i,
  input  logic [7:0]            wdata_i,
  input  logic [ROM_BANK_W:0]   rom_banks_i,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  ram_en_o
);
  localparam int RAM_BANKS = 1 << RAM_BANK_W;

  logic [ROM_BANK_W-1:0] cand;
  logic [NARROW_W-1:0]   low_n;
  logic [ROM_BANK_W-1:0] low_w;
  logic                  active, bank_ok;

  always_comb begin
    low_n = wdata_i[NARROW_W-1:0];
    low_w = wdata_i[ROM_BANK_W-1:0];
    cand  = rom_bank_o;
    unique case (mode_i)
      MODE_NARROW: begin
        cand[NARROW_W-1:0] = (low_n == '0) ? NARROW_W'(1) : low_n;
      end
      MODE_WSEL: cand = (low_w == '0) ? ROM_BANK_W'(1) : low_w;
      MODE_WRAW: cand = low_w;
      default:   cand = rom_bank_o;
    endcase
  end

  assign active  = (mode_i == MODE_NARROW) || (mode_i == MODE_WSEL) || (mode_i == MODE_WRAW);
  assign bank_ok = {1'b0, cand} < rom_banks_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_o <= ROM_BANK_W'(1);
      ram_bank_o <= '0;
      ram_en_o   <= 1'b0;
    end else if (we_i && active) begin
      if (sel_i == 3'd0) begin
        if (wdata_i == 8'h0A)      ram_en_o <= 1'b1;
        else if (wdata_i == 8'h00) ram_en_o <= 1'b0;
      end
      if (sel_i == 3'd1 && bank_ok) rom_bank_o <= cand;
      if (sel_i == 3'd2 && mode_i == MODE_WSEL && int'(wdata_i) < RAM_BANKS)
        ram_bank_o <= wdata_i[RAM_BANK_W-1:0];
    end
  end

  // R4 R5
  bank_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NARROW || mode_i == MODE_WSEL) |-> rom_bank_o != '0);
  // R8
  bank_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rom_bank_o) |-> {1'b0, rom_bank_o} < rom_banks_i);
  // R7
  ram_bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != MODE_WSEL |=> $stable(ram_bank_o));
  // R3
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'd0 && wdata_i != 8'h0A && wdata_i != 8'h00) |=> $stable(ram_en_o));
  // R9
  idle_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NONE || mode_i == MODE_OFF) |=> $stable(rom_bank_o) && $stable(ram_en_o));
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW    = ROM_BANK_W + 14,
  localparam int RAM_AW    = RAM_BANK_W + 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [15:0]           addr_i,
  input  logic                  we_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic [RAM_BANK_W-1:0] ram_bank_i,
  input  logic                  ram_en_i,
  input  logic [7:0]            ram_rdata_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_we_o,
  output logic [7:0]            bus_rdata_o
);
  logic in_ram;

  assign in_ram      = addr_i[15:13] == 3'b101;
  assign rom_addr_o  = {(addr_i[14] ? rom_bank_i : '0), addr_i[13:0]};
  assign ram_addr_o  = {ram_bank_i, addr_i[12:0]};
  assign ram_we_o    = we_i && in_ram && ram_en_i;
  assign bus_rdata_o = ram_en_i ? ram_rdata_i : 8'hFF;

  // R11
  ram_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_en_i |-> !ram_we_o && bus_rdata_o == 8'hFF);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  parameter int NARROW_W   = 5,
  localparam int ROM_AW    = ROM_BANK_W + 14,
  localparam int RAM_AW    = RAM_BANK_W + 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [7:0]            cart_type_i,
  input  logic [ROM_BANK_W:0]   rom_banks_i,
  input  logic [15:0]           bus_addr_i,
  input  logic [7:0]            bus_wdata_i,
  input  logic                  bus_we_i,
  input  logic [7:0]            ram_rdata_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  ram_en_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_we_o,
  output logic [7:0]            bus_ram_rdata_o
);
  cart_mode_e mode;
  logic       cfg_done;

  cart_mode_latch u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cart_type_i (cart_type_i),
    .mode_o      (mode),
    .cfg_done_o  (cfg_done)
  );

  cart_bank_regs #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .NARROW_W   (NARROW_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .we_i        (bus_we_i && cfg_done && !bus_addr_i[15]),
    .sel_i       (bus_addr_i[15:13]),
    .wdata_i     (bus_wdata_i),
    .rom_banks_i (rom_banks_i),
    .rom_bank_o  (rom_bank_o),
    .ram_bank_o  (ram_bank_o),
    .ram_en_o    (ram_en_o)
  );

  cart_addr_map #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W)
  ) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (bus_addr_i),
    .we_i        (bus_we_i),
    .rom_bank_i  (rom_bank_o),
    .ram_bank_i  (ram_bank_o),
    .ram_en_i    (ram_en_o),
    .ram_rdata_i (ram_rdata_i),
    .rom_addr_o  (rom_addr_o),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .bus_rdata_o (bus_ram_rdata_o)
  );
endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cart_type = 8'h00;
  logic [7:0]  rom_banks = 8'd128;
  logic [15:0] addr = 16'h8000;
  logic [7:0]  wdata = 8'h00;
  logic        we = 1'b0;
  logic [7:0]  rdata_in = 8'h00;
  logic [20:0] rom_addr;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        ram_en;
  logic [14:0] ram_addr;
  logic        ram_we;
  logic [7:0]  bus_rdata;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cart_type_i(cart_type), .rom_banks_i(rom_banks),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .ram_rdata_i(rdata_in),
    .rom_addr_o(rom_addr), .rom_bank_o(rom_bank), .ram_bank_o(ram_bank), .ram_en_o(ram_en),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .bus_ram_rdata_o(bus_rdata)
  );

  // reference model: 0 none, 1 narrow, 2 wide-sel, 3 wide-raw, 4 ignore-all
  int m_mode, m_bank, m_rbank;
  bit m_en, m_cfg;

  function automatic int model_decode(int t);
    case (t)
      'h00, 'h08, 'h09:                   return 0;
      'h01, 'h02, 'h03:                   return 1;
      'h0F, 'h10, 'h11, 'h12, 'h13:       return 2;
      'h05, 'h06, 'h15, 'h16, 'h17, 'h22: return 4;
      default:                            return 3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_bank = 1; m_rbank = 0; m_en = 0; m_cfg = 0;
    end else if (!m_cfg) begin
      m_cfg = 1; m_mode = model_decode(int'(cart_type));
    end else if (we && m_mode >= 1 && m_mode <= 3 && addr < 16'h8000) begin
      int nb;
      int v;
      if (addr < 16'h2000) begin
        if (wdata == 8'h0A) m_en = 1;
        else if (wdata == 8'h00) m_en = 0;
      end else if (addr < 16'h4000) begin
        if (m_mode == 1) begin
          v = wdata % 32; if (v == 0) v = 1;
          nb = (m_bank / 32) * 32 + v;
        end else begin
          nb = wdata % 128;
          if (m_mode == 2 && nb == 0) nb = 1;
        end
        if ((nb + 1) * 16384 <= int'(rom_banks) * 16384) m_bank = nb;
      end else if (addr < 16'h6000) begin
        if (m_mode == 2 && wdata < 4) m_rbank = wdata;
      end
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string bank_tag();
    case (m_mode)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R9";
    endcase
  endfunction

  // compare every clock, 2 ns before the rising edge
  always @(negedge clk) begin
    #8;
    if (rst_n && !done) begin
      bit win;
      win = addr >= 16'hA000 && addr < 16'hC000;
      chk(bank_tag(), rom_bank, m_bank, "rom_bank");
      chk("R7", ram_bank, m_rbank, "ram_bank");
      chk("R3", ram_en, m_en, "ram_en");
      if (addr < 16'h8000)
        chk("R10", rom_addr, addr[14] ? m_bank * 16384 + addr % 16384 : addr % 16384, "rom_addr");
      if (win) chk("R11", ram_addr, m_rbank * 8192 + addr % 8192, "ram_addr");
      chk("R11", ram_we, we && win && m_en, "ram_we");
      chk("R11", bus_rdata, m_en ? rdata_in : 8'hFF, "ram_rdata");
    end
  end

  task automatic op(logic [15:0] a, logic [7:0] d, logic w);
    @(negedge clk); #1;
    addr = a; wdata = d; we = w; rdata_in = 8'($urandom);
  endtask

  task automatic start(logic [7:0] t, logic [7:0] nb);
    @(negedge clk); #1;
    rst_n = 1'b0; we = 1'b0; cart_type = t; rom_banks = nb;
    @(negedge clk); #1;
    // R1: reset values visible while held
    vectors++;
    if (rom_bank != 7'd1 || ram_bank != 2'd0 || ram_en != 1'b0) begin
      misses++;
      $display("FAIL R1 reset actual=%0h/%0h/%0h expected=1/0/0", rom_bank, ram_bank, ram_en);
    end
    // R12: write on the bus in the capture cycle
    addr = 16'h0000; wdata = 8'h0A; we = 1'b1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R12", ram_en, 0, "ram_en after capture-cycle write");
    we = 1'b0;
  endtask

  initial begin
    logic [7:0] types [12] = '{8'h00, 8'h08, 8'h09, 8'h01, 8'h03, 8'h0F, 8'h13,
                               8'h19, 8'h1E, 8'h05, 8'h22, 8'hFF};
    logic [7:0] sizes [12] = '{8'd2, 8'd128, 8'd4, 8'd32, 8'd4, 8'd128, 8'd8,
                               8'd64, 8'd2, 8'd16, 8'd128, 8'd4};
    for (int k = 0; k < 12; k++) begin
      int em;
      start(types[k], sizes[k]);
      em = model_decode(int'(types[k]));
      // R2: a zero bank write exposes the decoded mode
      op(16'h2100, 8'h00, 1'b1);
      op(16'h8000, 8'h00, 1'b0);
      #8;
      chk("R2", rom_bank, (em == 3 && sizes[k] > 0) ? 0 : 1, "bank after zero write");
      // R8: last legal and first illegal bank
      op(16'h3FFF, sizes[k] - 8'd1, 1'b1);
      op(16'h2000, sizes[k], 1'b1);
      op(16'h4000, 8'h04, 1'b1);
      op(16'h5FFF, 8'h03, 1'b1);
      op(16'h1000, 8'h0A, 1'b1);
      op(16'h1000, 8'h05, 1'b1);
      op(16'hA123, 8'h5A, 1'b1);
      op(16'hBFFF, 8'h00, 1'b0);
      op(16'h0000, 8'h00, 1'b1);
      op(16'hA000, 8'h11, 1'b1);
      for (int i = 0; i < 400; i++) begin
        logic [15:0] a;
        logic [7:0]  d;
        int r;
        int p;
        r = $urandom % 6;
        case (r)
          0: a = 16'($urandom % 'h2000);
          1: a = 16'h2000 + 16'($urandom % 'h2000);
          2: a = 16'h4000 + 16'($urandom % 'h2000);
          3: a = 16'h6000 + 16'($urandom % 'h2000);
          4: a = 16'hA000 + 16'($urandom % 'h2000);
          default: a = 16'h8000 + 16'($urandom % 'h8000);
        endcase
        p = $urandom % 100;
        if (p < 25)      d = 8'h0A;
        else if (p < 40) d = 8'h00;
        else if (p < 60) d = 8'($urandom % 8);
        else             d = 8'($urandom);
        op(a, d, ($urandom % 10) < 7);
      end
    end
    op(16'h8000, 8'h00, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    misses++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule